// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block gives a processor 24 general-purpose parallel lines, grouped as two full 8-bit ports (A and B) and one 8-bit port C. Port C splits into two nibbles. The upper nibble belongs with port A as group A, and the lower nibble belongs with port B as group B. The processor reaches the block over a small byte-wide bus. That bus has two register-select bits and active-low select, read and write strobes. Each pad is modelled as a separate input, output-latch value and output enable, so the pad ring outside the block builds the actual tristate pins.

A single control address accepts two kinds of command, told apart by the top bit of the written byte. A mode word (top bit 1) sets the direction of port A, port B and each port C nibble, and clears every output latch. A bit command (top bit 0) forces one chosen port C latch bit to 0 or 1 and leaves the other seven alone. Only the plain latched-output and buffered-input behaviour is implemented. Any handshake mode requested in a mode word is accepted, and the group then behaves as plain I/O.

The strobes are sampled on the block clock. A write is committed at the first clock edge that sees the write strobe (or chip select) released after an active low phase. A read drives the data bus combinationally for as long as select and read are both low.

Top module: `pario_hub`

## Requirements
- R1: While `rst` is high and after it falls, every port enable (`pa_oe`, `pb_oe`, `pc_oe`) is 0, so every port is an input. Every output latch is 0, and `dout_oe` is 0 unless a read is active.
- R2: With `cs_n` high, `dout_oe` stays 0 and a low pulse on `wr_n` changes no latch or configuration.
- R3: `dout_oe` is 1 exactly while `cs_n` and `rd_n` are both low, in the same cycle without any clock delay. When `dout_oe` is 0, `dout` is 0.
- R4: A write takes effect at the first rising clock edge at which `cs_n`/`wr_n` are no longer both low, after at least one edge with both low. The address and data used are those held during the low phase.
- R5: `addr` selects port A (0), port B (1), port C (2) or the control register (3). A read of address 3 returns 0xFF.
- R6: A write to address 3 with bit 7 = 1 is a mode word, laid out as follows:
  - bits 6..5: group A mode
  - bit 4: port A direction
  - bit 3: direction of upper port C (bits 7..4)
  - bit 2: group B mode
  - bit 1: port B direction
  - bit 0: direction of lower port C (bits 3..0)

  A direction of 1 means input (enable 0), and 0 means output (enable all ones). For example, 0x88 makes port A, port B and lower C outputs and upper C an input.
- R7: Every mode word write clears the port A, B and C output latches to 0.
- R8: A write to address 3 with bit 7 = 0 is a bit command. Bits 3..1 select the port C bit number and bit 0 gives its new value. Bits 6..4 are ignored, and the other seven port C latch bits keep their values.
- R9: A port read returns the live input pins for bits set as input and the output latch for bits set as output. For port C this is decided separately for each nibble.
- R10: A mode word that requests a non-zero mode for either group is accepted. Its direction bits apply, and the ports behave as plain latched outputs and buffered inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst | input | 1 | Active-high asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor, 0 when not driven |
| dout_oe | output | 1 | Read data enable toward the bus |
| pa_in | input | 8 | Port A pad inputs |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A pad enables, 1 = drive |
| pb_in | input | 8 | Port B pad inputs |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B pad enables, 1 = drive |
| pc_in | input | 8 | Port C pad inputs |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C pad enables, 1 = drive |

## Verification
Read results are due in the same cycle as the strobes. The bench therefore samples `dout` and `dout_oe` partway into the low half of the clock while the read is still held, and never waits on an edge. Write results, whether latches, enables or bit-command effects, are due one edge after the strobe release. The bench holds the strobes low across one rising edge, releases them at a falling edge, lets exactly one further rising edge pass and samples at the next falling edge. Ignored writes (chip select high) are checked at that same point, by observing that the latch outputs did not move and by reading the port back.

// File: rtl/pario_pkg.sv
package pario_pkg;

  localparam int PORT_W = 8;
  localparam int NIB_W  = PORT_W / 2;
  localparam int IDX_W  = $clog2(PORT_W);

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

  // direction flags, 1 = input
  typedef struct packed {
    logic in_a;
    logic in_cu;
    logic in_b;
    logic in_cl;
  } dir_cfg_t;

  localparam dir_cfg_t DIR_RESET = '{in_a: 1'b1, in_cu: 1'b1, in_b: 1'b1, in_cl: 1'b1};
  localparam logic [PORT_W-1:0] CTL_READ_VAL = '1;

  function automatic dir_cfg_t decode_dirs(input logic [7:0] w);
    dir_cfg_t d;
    d.in_a  = w[4];
    d.in_cu = w[3];
    d.in_b  = w[1];
    d.in_cl = w[0];
    return d;
  endfunction

  function automatic logic [IDX_W-1:0] bit_cmd_index(input logic [7:0] w);
    return w[IDX_W:1];
  endfunction

  function automatic logic [PORT_W-1:0] full_mask(input logic input_dir);
    return input_dir ? '0 : '1;
  endfunction

  function automatic logic [PORT_W-1:0] split_mask(input logic in_hi, input logic in_lo);
    logic [NIB_W-1:0] hi;
    logic [NIB_W-1:0] lo;
    hi = in_hi ? '0 : '1;
    lo = in_lo ? '0 : '1;
    return {hi, lo};
  endfunction

  // pads for input bits, latch for output bits
  function automatic logic [PORT_W-1:0] port_view(input logic [PORT_W-1:0] lat,
                                                  input logic [PORT_W-1:0] pins,
                                                  input logic [PORT_W-1:0] drive);
    return (lat & drive) | (pins & ~drive);
  endfunction

endpackage

// File: rtl/pario_bus_if.sv
module pario_bus_if
  import pario_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] din,
  output logic              rd_en,
  output logic              wr_commit,
  output reg_sel_e          wr_sel,
  output logic [PORT_W-1:0] wr_data
);

  logic wr_active;
  logic wr_active_q;

  assign wr_active = !cs_n && !wr_n;
  assign rd_en     = !cs_n && !rd_n;
  assign wr_commit = wr_active_q && !wr_active;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wr_active_q <= 1'b0;
      wr_sel      <= SEL_A;
      wr_data     <= '0;
    end else begin
      wr_active_q <= wr_active;
      if (wr_active) begin
        wr_sel  <= reg_sel_e'(addr);
        wr_data <= din;
      end
    end
  end

endmodule

// File: rtl/pario_ctrl.sv
module pario_ctrl
  import pario_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_commit,
  input  reg_sel_e          wr_sel,
  input  logic [PORT_W-1:0] wr_data,
  output dir_cfg_t          dirs,
  output logic              mode_hit,
  output logic              bsr_hit
);

  logic ctl_hit;
  logic mode_field_unused;

  assign ctl_hit  = wr_commit && (wr_sel == SEL_CTL);
  assign mode_hit = ctl_hit && wr_data[7];
  assign bsr_hit  = ctl_hit && !wr_data[7];

  // requested handshake modes are accepted and then run as plain I/O
  assign mode_field_unused = ^{wr_data[6:5], wr_data[2]};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dirs <= DIR_RESET;
    end else if (mode_hit) begin
      dirs <= decode_dirs(wr_data);
    end
  end

endmodule

// File: rtl/pario_latches.sv
module pario_latches
  import pario_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_commit,
  input  reg_sel_e          wr_sel,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              mode_hit,
  input  logic              bsr_hit,
  output logic [PORT_W-1:0] pa_lat,
  output logic [PORT_W-1:0] pb_lat,
  output logic [PORT_W-1:0] pc_lat
);

  logic [IDX_W-1:0] bit_idx;
  logic             bit_val;
  logic             wr_a;
  logic             wr_b;
  logic             wr_c;

  assign bit_idx = bit_cmd_index(wr_data);
  assign bit_val = wr_data[0];
  assign wr_a    = wr_commit && (wr_sel == SEL_A);
  assign wr_b    = wr_commit && (wr_sel == SEL_B);
  assign wr_c    = wr_commit && (wr_sel == SEL_C);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pa_lat <= '0;
      pb_lat <= '0;
    end else if (mode_hit) begin
      pa_lat <= '0;
      pb_lat <= '0;
    end else begin
      if (wr_a) pa_lat <= wr_data;
      if (wr_b) pb_lat <= wr_data;
    end
  end

  // one slice per port C bit: whole-byte write or single-bit command
  for (genvar i = 0; i < PORT_W; i++) begin : g_pc_bit
    logic hit_i;
    assign hit_i = bsr_hit && (bit_idx == IDX_W'(i));

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        pc_lat[i] <= 1'b0;
      end else if (mode_hit) begin
        pc_lat[i] <= 1'b0;
      end else if (wr_c) begin
        pc_lat[i] <= wr_data[i];
      end else if (hit_i) begin
        pc_lat[i] <= bit_val;
      end
    end
  end

endmodule

// File: rtl/pario_hub.sv
module pario_hub
  import pario_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] din,
  output logic [PORT_W-1:0] dout,
  output logic              dout_oe,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);

  logic              rd_en;
  logic              wr_commit;
  reg_sel_e          wr_sel;
  logic [PORT_W-1:0] wr_data;
  dir_cfg_t          dirs;
  logic              mode_hit;
  logic              bsr_hit;
  logic [PORT_W-1:0] rd_mux;

  pario_bus_if u_bus (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .addr      (addr),
    .din       (din),
    .rd_en     (rd_en),
    .wr_commit (wr_commit),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data)
  );

  pario_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_commit (wr_commit),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .dirs      (dirs),
    .mode_hit  (mode_hit),
    .bsr_hit   (bsr_hit)
  );

  pario_latches u_lat (
    .clk       (clk),
    .rst       (rst),
    .wr_commit (wr_commit),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .mode_hit  (mode_hit),
    .bsr_hit   (bsr_hit),
    .pa_lat    (pa_out),
    .pb_lat    (pb_out),
    .pc_lat    (pc_out)
  );

  assign pa_oe = full_mask(dirs.in_a);
  assign pb_oe = full_mask(dirs.in_b);
  assign pc_oe = split_mask(dirs.in_cu, dirs.in_cl);

  always_comb begin
    unique case (reg_sel_e'(addr))
      SEL_A:   rd_mux = port_view(pa_out, pa_in, pa_oe);
      SEL_B:   rd_mux = port_view(pb_out, pb_in, pb_oe);
      SEL_C:   rd_mux = port_view(pc_out, pc_in, pc_oe);
      default: rd_mux = CTL_READ_VAL;
    endcase
  end

  assign dout_oe = rd_en;
  assign dout    = rd_en ? rd_mux : '0;

endmodule

// File: rtl/pario_hub_chk.sv
module pario_hub_chk
  import pario_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [1:0]        addr,
  input logic [PORT_W-1:0] dout,
  input logic              dout_oe,
  input logic [PORT_W-1:0] pa_out,
  input logic [PORT_W-1:0] pb_out,
  input logic [PORT_W-1:0] pc_out,
  input logic              wr_commit,
  input logic              mode_hit,
  input logic              bsr_hit
);

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !dout_oe) else $error("deselected bus driven"); // R2

  AST_DESELECT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n)) |-> !wr_commit) else $error("write while deselected"); // R2

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    dout_oe |-> (!cs_n && !rd_n)) else $error("data enable without read"); // R3

  AST_COMMIT_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> $past(!cs_n && !wr_n)) else $error("commit without strobe"); // R4

  AST_CTL_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    (dout_oe && addr == 2'd3) |-> dout == 8'hFF) else $error("control read value"); // R5

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    mode_hit |=> (pa_out == '0 && pb_out == '0 && pc_out == '0)) else $error("latches not cleared"); // R7

  AST_BIT_CMD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bsr_hit |=> $countones(pc_out ^ $past(pc_out)) <= 1) else $error("bit command moved several bits"); // R8

  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mode_hit, bsr_hit})) else $error("both command kinds"); // R8

endmodule

bind pario_hub pario_hub_chk chk_i (.*);

// File: tb/pario_hub_tb_top.sv
`timescale 1ns/1ps
module pario_hub_tb_top;

  typedef enum int {OB_DOUT, OB_DOE, OB_PA, OB_PAOE, OB_PB, OB_PBOE, OB_PC, OB_PCOE} obs_e;
  typedef struct {
    obs_e       obs;
    logic [7:0] exp;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_oe;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   finished = 1'b0;
  item_t sb_q[$];
  event  chk_ev;

  always #10 clk = ~clk;

  pario_hub dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  function automatic logic [7:0] observe(obs_e o);
    case (o)
      OB_DOUT: return dout;
      OB_DOE:  return {7'd0, dout_oe};
      OB_PA:   return pa_out;
      OB_PAOE: return pa_oe;
      OB_PB:   return pb_out;
      OB_PBOE: return pb_oe;
      OB_PC:   return pc_out;
      default: return pc_oe;
    endcase
  endfunction

  // monitor: pops expected items and compares with live outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sb_q.pop_front();
        act = observe(it.obs);
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s: actual %02h expected %02h", it.req, it.obs.name(), act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(obs_e o, logic [7:0] e, string r);
    item_t it;
    it.obs = o; it.exp = e; it.req = r;
    sb_q.push_back(it);
  endtask

  task automatic flush();
    -> chk_ev;
    wait (sb_q.size() == 0);
  endtask

  // write cycle: strobes low over one edge, released at a falling edge;
  // effect due at the next rising edge, sampled at the falling edge after
  task automatic bus_write(logic [1:0] a, logic [7:0] d, logic sel_n);
    @(negedge clk);
    cs_n = sel_n; wr_n = 1'b0; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  // read: strobes applied at a falling edge, sampled 5 ns later, same cycle
  task automatic bus_read(logic [1:0] a, logic [7:0] e, string r);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    #5;
    expect_val(OB_DOE, 8'h01, r);
    expect_val(OB_DOUT, e, r);
    flush();
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic expect_ports(logic [7:0] a, logic [7:0] b, logic [7:0] c, string r);
    expect_val(OB_PA, a, r);
    expect_val(OB_PB, b, r);
    expect_val(OB_PC, c, r);
    flush();
  endtask

  task automatic expect_oes(logic [7:0] a, logic [7:0] b, logic [7:0] c, string r);
    expect_val(OB_PAOE, a, r);
    expect_val(OB_PBOE, b, r);
    expect_val(OB_PCOE, c, r);
    flush();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: state during reset
    expect_oes(8'h00, 8'h00, 8'h00, "R1");
    expect_ports(8'h00, 8'h00, 8'h00, "R1");
    expect_val(OB_DOE, 8'h00, "R1"); flush();
    rst = 1'b0;
    @(negedge clk);
    expect_oes(8'h00, 8'h00, 8'h00, "R1");

    // R5/R3: control address reads as all ones
    bus_read(2'd3, 8'hFF, "R5");
    // R9: port A input after reset shows pins
    pa_in = 8'h5A;
    bus_read(2'd0, 8'h5A, "R9");

    // R6: 0x88 -> A, B, lower C outputs; upper C input
    bus_write(2'd3, 8'h88, 1'b0);
    expect_oes(8'hFF, 8'hFF, 8'h0F, "R6");

    // R4: port writes land one edge after release
    bus_write(2'd0, 8'h3C, 1'b0);
    expect_ports(8'h3C, 8'h00, 8'h00, "R4");
    bus_write(2'd1, 8'hA5, 1'b0);
    expect_ports(8'h3C, 8'hA5, 8'h00, "R4");
    bus_read(2'd0, 8'h3C, "R9");

    // R2: writes with select high are ignored
    bus_write(2'd0, 8'hFF, 1'b1);
    bus_write(2'd3, 8'h9B, 1'b1);
    expect_ports(8'h3C, 8'hA5, 8'h00, "R2");
    expect_oes(8'hFF, 8'hFF, 8'h0F, "R2");
    bus_read(2'd0, 8'h3C, "R2");
    // R2: read strobe with select high keeps bus off
    @(negedge clk);
    rd_n = 1'b0; addr = 2'd0;
    #5;
    expect_val(OB_DOE, 8'h00, "R2");
    expect_val(OB_DOUT, 8'h00, "R3");
    flush();
    @(negedge clk);
    rd_n = 1'b1;

    // R8: bit commands; bits 6..4 set but ignored
    bus_write(2'd3, 8'h7B, 1'b0);   // bit 5 := 1
    expect_ports(8'h3C, 8'hA5, 8'h20, "R8");
    bus_write(2'd3, 8'h01, 1'b0);   // bit 0 := 1
    expect_ports(8'h3C, 8'hA5, 8'h21, "R8");
    bus_write(2'd3, 8'h0A, 1'b0);   // bit 5 := 0
    expect_ports(8'h3C, 8'hA5, 8'h01, "R8");
    bus_write(2'd3, 8'h0F, 1'b0);   // bit 7 := 1
    expect_ports(8'h3C, 8'hA5, 8'h81, "R8");
    expect_oes(8'hFF, 8'hFF, 8'h0F, "R8");

    // R9: port C nibble split, upper from pins, lower from latch
    pc_in = 8'hF0;
    bus_read(2'd2, 8'hF1, "R9");

    // R10/R7: handshake modes requested, all outputs, latches cleared
    bus_write(2'd3, 8'hC4, 1'b0);
    expect_ports(8'h00, 8'h00, 8'h00, "R7");
    expect_oes(8'hFF, 8'hFF, 8'hFF, "R10");
    bus_write(2'd0, 8'h77, 1'b0);
    expect_ports(8'h77, 8'h00, 8'h00, "R10");
    bus_read(2'd0, 8'h77, "R10");
    bus_write(2'd2, 8'h96, 1'b0);
    bus_read(2'd2, 8'h96, "R9");

    // R6/R9: all inputs; reads follow the pins
    bus_write(2'd3, 8'h9B, 1'b0);
    expect_oes(8'h00, 8'h00, 8'h00, "R6");
    pb_in = 8'hC3;
    bus_read(2'd1, 8'hC3, "R9");

    // R1: reset mid-run restores input mode and clears latches
    bus_write(2'd3, 8'h80, 1'b0);
    bus_write(2'd1, 8'h55, 1'b0);
    expect_ports(8'h00, 8'h55, 8'h00, "R4");
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    expect_oes(8'h00, 8'h00, 8'h00, "R1");
    expect_ports(8'h00, 8'h00, 8'h00, "R1");
    rst = 1'b0;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule